// File: doc/BRIEF.md
# Self-Timed Programming Controller for a Serial Nonvolatile Memory

This block sits behind the command decoder of a three-wire serial memory. It handles the four modifying commands: clear one location, program one location, clear the whole array and program the whole array. Each command is committed to the storage array through a timed internal cycle. The decoder hands over a request once it has sampled the final bit of a frame. The controller then watches the select pin (S) and the serial clock pin (C). The internal cycle starts only if S is released before the next rising edge of C. Otherwise the request is dropped and nothing in the array changes.

Once a cycle has started, it runs for a fixed number of system clock cycles, whether C keeps toggling or not. During that time the controller performs an erase pass first. It writes all ones to every targeted location. A program command then gets a data pass, which writes the new value to the same locations. While a cycle is running, a host that raises S again sees busy on the serial output. Once the cycle is finished, the host sees ready.

The request side uses a valid/ready handshake, but it has no back-pressure in the usual sense. `req_ready` is high only when the controller is idle. A request offered while `req_ready` is low is discarded. The decoder must not hold a request and retry it. The pins S and C are sampled in the system clock domain, so they must already be synchronised.

Top module: `ee_prog_ctrl`

## Requirements
- R1: After reset `req_ready` is 1, `q_oe` is 0 and `mem_we` is 0. A request is taken in a cycle where `req_valid` and `req_ready` are both 1.
- R2: A request taken while `cs` is 1 starts a cycle if a falling edge of `cs` is seen after acceptance and before any rising edge of `sclk`.
- R3: If a rising edge of `sclk` is seen after acceptance and before `cs` falls, no cycle starts and the controller makes no memory writes.
- R4: A request taken while `cs` is already 0 never starts a cycle and causes no memory writes.
- R5: Op code 0 (erase one location) makes exactly one write: all ones to `req_addr`.
- R6: Op code 2 (erase all) writes all ones to every address, in ascending order starting at 0, one write per clock.
- R7: Op code 1 (program one location) writes all ones to `req_addr` and then, on the next clock, `req_data` to the same address.
- R8: Op code 3 (program all) first writes all ones to every address in ascending order. It then writes `req_data` to every address in ascending order, with no gap between the two passes.
- R9: Busy lasts exactly PROG_CYCLES system clock cycles, counted from the clock after `cs` falls, whether or not `sclk` toggles during that time.
- R10: `q_oe` is 1 only while `cs` is 1 and either a cycle is running or a cycle has finished since the last falling edge of `cs`. While a cycle is running `q_out` is 0 (busy). After the cycle finishes `q_out` is 1 (ready).
- R11: While a cycle is running `req_ready` is 0. A request offered during that time is ignored and causes no memory writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Decoded modifying command is offered |
| req_ready | output | 1 | Controller is idle and will take the command |
| req_op | input | 2 | 0 erase one, 1 program one, 2 erase all, 3 program all |
| req_addr | input | ADDR_W | Target location for the single-location commands |
| req_data | input | DATA_W | Value to program |
| cs | input | 1 | Select pin S, already synchronised |
| sclk | input | 1 | Serial clock pin C, already synchronised |
| mem_we | output | 1 | Array write strobe; the array takes one write per clock |
| mem_addr | output | ADDR_W | Array write address |
| mem_wdata | output | DATA_W | Array write data |
| q_out | output | 1 | Status value for pin Q: 0 busy, 1 ready |
| q_oe | output | 1 | Drive enable for pin Q; when 0, Q is released |

## Verification
The bound assertions check four things on every clock. Every data write follows an erase write on the clock before it. A rising C edge while armed never leads to busy. Busy never begins except from the armed state. Each busy period lasts exactly PROG_CYCLES clocks. They also check that a request accepted with S low leaves the controller idle, and that the array is never written while a request could be accepted. Other behaviour can only be shown by the bench's sweep over every op code, every address and each of the three release timings. That covers the exact order and values of the array writes, the busy/ready levels seen through polling with C toggling, and a request dropped during a cycle leaving the array untouched.

// File: rtl/ee_prog_pkg.sv
package ee_prog_pkg;
  typedef enum logic [1:0] {
    OP_ERASE     = 2'd0,
    OP_WRITE     = 2'd1,
    OP_ERASE_ALL = 2'd2,
    OP_WRITE_ALL = 2'd3
  } ee_op_e;
endpackage

// File: rtl/ee_start_gate.sv
module ee_start_gate
  import ee_prog_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  input  logic              cs,
  input  logic              cs_fall,
  input  logic              sclk_rise,
  input  logic              busy,
  output logic              req_ready,
  output logic              armed,
  output logic              start,
  output ee_op_e            op_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] data_q
);
  logic accept;

  assign req_ready = ~armed & ~busy;
  assign accept    = req_valid & req_ready;
  // the window closes on the first C rise; a C rise wins a tie
  assign start     = armed & cs_fall & ~sclk_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed  <= 1'b0;
      op_q   <= OP_ERASE;
      addr_q <= '0;
      data_q <= '0;
    end else if (accept) begin
      armed  <= cs;
      op_q   <= ee_op_e'(req_op);
      addr_q <= req_addr;
      data_q <= req_data;
    end else if (armed && (sclk_rise || cs_fall)) begin
      armed  <= 1'b0;
    end
  end
endmodule

// File: rtl/ee_prog_seq.sv
module ee_prog_seq
  import ee_prog_pkg::*;
#(
  parameter int ADDR_W      = 3,
  parameter int DATA_W      = 8,
  parameter int PROG_CYCLES = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  ee_op_e            op,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  output logic              busy,
  output logic              done,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata
);
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int CW_T   = $clog2(PROG_CYCLES + 1);
  localparam int CNT_W  = (CW_T > ADDR_W + 2) ? CW_T : ADDR_W + 2;
  localparam logic [CNT_W-1:0] LAST   = CNT_W'(PROG_CYCLES);
  localparam logic [CNT_W-1:0] DEPTHC = CNT_W'(DEPTH);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] step;
  logic [CNT_W-1:0] pstep;
  logic             whole;
  logic             prog;

  assign busy  = (cnt != '0);
  assign done  = busy && (cnt == LAST);
  assign step  = cnt - 1'b1;
  assign pstep = step - DEPTHC;
  assign whole = (op == OP_ERASE_ALL) || (op == OP_WRITE_ALL);
  assign prog  = (op == OP_WRITE) || (op == OP_WRITE_ALL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (start) cnt <= CNT_W'(1);
    else if (busy)  cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
  end

  always_comb begin
    mem_we    = 1'b0;
    mem_addr  = addr;
    mem_wdata = '1;
    if (busy) begin
      if (!whole) begin
        if (step == '0) begin
          mem_we = 1'b1;
        end else if (prog && step == CNT_W'(1)) begin
          mem_we    = 1'b1;
          mem_wdata = data;
        end
      end else begin
        if (step < DEPTHC) begin
          mem_we   = 1'b1;
          mem_addr = step[ADDR_W-1:0];
        end else if (prog && step < 2 * DEPTHC) begin
          mem_we    = 1'b1;
          mem_addr  = pstep[ADDR_W-1:0];
          mem_wdata = data;
        end
      end
    end
  end
endmodule

// File: rtl/ee_status_drv.sv
module ee_status_drv (
  input  logic clk,
  input  logic rst_n,
  input  logic cs,
  input  logic cs_fall,
  input  logic busy,
  input  logic done,
  output logic q_out,
  output logic q_oe
);
  logic finished;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       finished <= 1'b0;
    else if (done)    finished <= 1'b1;
    else if (cs_fall) finished <= 1'b0;
  end

  assign q_oe  = cs & (busy | finished);
  assign q_out = ~busy;
endmodule

// File: rtl/ee_prog_ctrl.sv
module ee_prog_ctrl
  import ee_prog_pkg::*;
#(
  parameter int ADDR_W      = 3,
  parameter int DATA_W      = 8,
  parameter int PROG_CYCLES = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  input  logic              cs,
  input  logic              sclk,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              q_out,
  output logic              q_oe
);
  logic              cs_q, sclk_q;
  logic              cs_fall, sclk_rise;
  logic              armed, start, busy, done;
  ee_op_e            op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q   <= 1'b0;
      sclk_q <= 1'b0;
    end else begin
      cs_q   <= cs;
      sclk_q <= sclk;
    end
  end

  assign cs_fall   = cs_q & ~cs;
  assign sclk_rise = ~sclk_q & sclk;

  ee_start_gate #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_gate (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_data(req_data), .cs(cs), .cs_fall(cs_fall),
    .sclk_rise(sclk_rise), .busy(busy), .req_ready(req_ready),
    .armed(armed), .start(start), .op_q(op_q), .addr_q(addr_q), .data_q(data_q)
  );

  ee_prog_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PROG_CYCLES(PROG_CYCLES)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op_q), .addr(addr_q),
    .data(data_q), .busy(busy), .done(done), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  ee_status_drv u_stat (
    .clk(clk), .rst_n(rst_n), .cs(cs), .cs_fall(cs_fall), .busy(busy),
    .done(done), .q_out(q_out), .q_oe(q_oe)
  );
endmodule

// File: rtl/ee_prog_ctrl_chk.sv
module ee_prog_ctrl_chk #(
  parameter int DATA_W      = 8,
  parameter int PROG_CYCLES = 40
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              cs,
  input logic              mem_we,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              busy,
  input logic              armed,
  input logic              sclk_rise
);
  int busy_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busy_len <= 0;
    else if (busy) busy_len <= busy_len + 1;
    else           busy_len <= 0;
  end

  // R11
  write_only_when_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !req_ready);

  // R4
  low_select_no_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !cs) |=> req_ready);

  // R3
  late_release_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && sclk_rise) |=> !busy);

  // R2
  busy_from_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(armed));

  // R7
  erase_before_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && mem_wdata != '1) |-> $past(mem_we));

  // R9
  busy_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> busy_len == PROG_CYCLES);
endmodule

bind ee_prog_ctrl ee_prog_ctrl_chk #(.DATA_W(DATA_W), .PROG_CYCLES(PROG_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .cs(cs), .mem_we(mem_we), .mem_wdata(mem_wdata), .busy(busy),
  .armed(armed), .sclk_rise(sclk_rise)
);

// File: tb/ee_prog_ctrl_tb.sv
module ee_prog_ctrl_tb;
  localparam int CLK_PERIOD  = 10;
  localparam int ADDR_W      = 3;
  localparam int DATA_W      = 8;
  localparam int PROG_CYCLES = 40;
  localparam int DEPTH       = 1 << ADDR_W;
  localparam int LOGN        = 1024;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic [1:0]        req_op = '0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [DATA_W-1:0] req_data = '0;
  logic              cs = 1'b0;
  logic              sclk = 1'b0;
  logic              mem_we;
  logic [ADDR_W-1:0] mem_addr;
  logic [DATA_W-1:0] mem_wdata;
  logic              q_out, q_oe;

  int checks = 0;
  int fails  = 0;
  int nlog   = 0;
  logic [ADDR_W-1:0] log_a [LOGN];
  logic [DATA_W-1:0] log_d [LOGN];

  ee_prog_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PROG_CYCLES(PROG_CYCLES)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_data(req_data), .cs(cs),
    .sclk(sclk), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .q_out(q_out), .q_oe(q_oe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (mem_we && nlog < LOGN) begin
      log_a[nlog] <= mem_addr;
      log_d[nlog] <= mem_wdata;
      nlog <= nlog + 1;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // mode 0: S released in window, 1: C rises first, 2: S already low
  task automatic run(input int op, input int a, input int d, input int mode);
    int base, bcount, nexp;
    string rq;
    @(negedge clk);
    cs = (mode != 2); sclk = 1'b0;
    @(negedge clk);
    base = nlog;
    req_valid = 1'b1; req_op = 2'(op); req_addr = ADDR_W'(a);
    req_data = DATA_W'(d); sclk = 1'b1;
    #1 chk("R1 ready when idle", req_ready, 1);
    @(negedge clk);
    req_valid = 1'b0; sclk = 1'b0;
    if (mode == 0) cs = 1'b0;
    if (mode == 1) begin
      @(negedge clk); sclk = 1'b1;
      @(negedge clk); sclk = 1'b0; cs = 1'b0;
    end
    if (mode == 0) begin
      bcount = 0;
      for (int i = 0; i < PROG_CYCLES + 10; i++) begin
        @(negedge clk);
        cs = 1'b1; sclk = ~sclk;
        req_valid = (i == 3);
        req_op = 2'd3;
        #1;
        if (i == 3) chk("R11 ready low while busy", req_ready, 0);
        if (q_oe && !q_out) bcount++;
        else break;
      end
      req_valid = 1'b0;
      chk("R9 busy length", bcount, PROG_CYCLES);
      chk("R10 ready drive", q_oe, 1);
      chk("R10 ready value", q_out, 1);
      @(negedge clk); cs = 1'b0; sclk = 1'b0;
      #1 chk("R10 released when S low", q_oe, 0);
    end
    repeat (3) @(negedge clk);
    if (mode != 0) begin
      cs = 1'b1;
      #1 chk("R3/R4 no status after drop", q_oe, 0);
      @(negedge clk); cs = 1'b0;
      @(negedge clk);
    end
    case (op)
      0: begin nexp = 1;         rq = "R5"; end
      1: begin nexp = 2;         rq = "R7"; end
      2: begin nexp = DEPTH;     rq = "R6"; end
      default: begin nexp = 2 * DEPTH; rq = "R8"; end
    endcase
    if (mode == 1) begin nexp = 0; rq = "R3"; end
    if (mode == 2) begin nexp = 0; rq = "R4"; end
    chk({rq, " write count (R2/R11)"}, nlog - base, nexp);
    for (int k = 0; k < nexp && base + k < LOGN; k++) begin
      int ea, ed;
      if (op == 0 || op == 1) begin
        ea = a; ed = (k == 0) ? 255 : d;
      end else begin
        ea = k % DEPTH; ed = (k < DEPTH) ? 255 : d;
      end
      chk({rq, " write addr"}, int'(log_a[base + k]), ea);
      chk({rq, " write data"}, int'(log_d[base + k]), ed);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 reset ready", req_ready, 1);
    chk("R1 reset q_oe", q_oe, 0);
    chk("R1 reset mem_we", mem_we, 0);
    for (int op = 0; op < 4; op++)
      for (int a = 0; a < DEPTH; a++)
        for (int m = 0; m < 3; m++)
          run(op, a, (a * 29 + op * 7 + 3) & 8'hFF, m);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule